// File: doc/BRIEF.md
# Banked Memory Paging Unit

This block sits between a CPU with a 16-bit memory address and a 20-bit physical memory system. It holds three ROM bank registers and one RAM configuration register. The CPU writes these registers with ordinary memory stores to the four highest addresses. Each store also reaches user RAM, because the top of the CPU space is user RAM. The CPU space splits into four 16 KB frames. Frames 0, 1 and 2 each map to a ROM bank chosen by their own register. Frame 3 is the 8 KB on-board user RAM, seen twice. The configuration register can replace frame 2 with a 16 KB page of battery-backed RAM or with video memory.

Only memory requests go through the unit. Port-mapped I/O requests never raise `memReq`, so the unit selects no device for them. The physical address and the device selects are combinational from the request. The registers change on the clock edge that ends a store cycle. The lowest 1 KB of the CPU space always reads ROM bank 0, so the reset and interrupt vectors stay in place whatever frame 0 selects.

Top module: `memory_pager`

## Requirements
- R1: After reset the bank registers for frames 0, 1 and 2 hold 0, 1 and 2, and the RAM configuration register holds 0.
- R2: A memory request at CPU address 0x0400 to 0x3FFF gives physAddr = {1'b0, frame-0 bank, cpuAddr[13:0]} with romSel high.
- R3: A memory request at CPU address 0x0000 to 0x03FF always gives physAddr = {6'b0, cpuAddr[13:0]}, which is ROM bank 0, with romSel high.
- R4: A memory request in 0x4000 to 0x7FFF maps as {1'b0, frame-1 bank, cpuAddr[13:0]}. A request in 0x8000 to 0xBFFF maps as {1'b0, frame-2 bank, cpuAddr[13:0]}, unless R7 or R8 applies. romSel is high in both cases.
- R5: A memory store (memReq and wrEn both high) updates a register on the next clock edge. The store goes to 0xFFFD for frame 0, 0xFFFE for frame 1 and 0xFFFF for frame 2, and the bank takes wrData[4:0]. A memory read of these addresses changes nothing.
- R6: A memory request in 0xC000 to 0xFFFF gives physAddr = {5'b11101, 2'b00, cpuAddr[12:0]} with uramSel high, so the upper 8 KB mirrors the lower 8 KB. Register stores also select user RAM.
- R7: A store to 0xFFFC loads the RAM configuration. When its bit 3 is set, frame 2 maps to {5'b10000, bit 2, cpuAddr[13:0]} with bramSel high. Frames 0, 1 and 3 do not change.
- R8: When configuration bit 4 is set and bit 3 is clear, frame 2 maps to {5'b11111, 1'b0, cpuAddr[13:0]} with vramSel high. Bit 3 takes priority over bit 4.
- R9: While memReq is low, all four selects are low and no register changes, even if wrEn is high at a register address.
- R10: While memReq is high, exactly one select is high. romSel goes with physAddr[19] = 0, uramSel with top bits 11101, vramSel with 11111, and bramSel with the other patterns that start with 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memReq | input | 1 | CPU memory request (I/O requests keep this low) |
| wrEn | input | 1 | Request is a store |
| cpuAddr | input | 16 | CPU memory address |
| wrData | input | 8 | Store data |
| physAddr | output | 20 | Translated physical address |
| romSel | output | 1 | ROM selected |
| bramSel | output | 1 | Battery-backed RAM selected |
| uramSel | output | 1 | On-board user RAM selected |
| vramSel | output | 1 | Video memory selected |

## Verification
The checker tests on every cycle the behaviours that follow from the current request alone:
- the select is one-hot while a request is active and all selects are low while it is idle;
- the vector kilobyte is pinned to bank 0;
- the user RAM mirror holds;
- the frame offset passes through to the physical address;
- a bank store shows up in the very next frame-1 access.

Only the bench's scenarios show the rest:
- the reset values of the registers;
- the substitution of battery RAM or video memory into frame 2 and the priority between the two;
- that idle cycles and plain reads leave the registers unchanged, which a later access reveals;
- that a second reset restores the initial mapping.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  localparam int CPU_AW     = 16;
  localparam int FRAME_AW   = 14;
  localparam int BANK_W     = 5;
  localparam int VEC_AW     = 10;
  localparam int URAM_AW    = 13;
  localparam int NUM_FRAMES = 3;
  localparam int TAG_W      = 5;
  localparam int PA_W       = TAG_W + 1 + FRAME_AW;
  localparam int NUM_REGS   = NUM_FRAMES + 1;

  localparam logic [TAG_W-1:0] TAG_BRAM = 5'b10000;
  localparam logic [TAG_W-1:0] TAG_URAM = 5'b11101;
  localparam logic [TAG_W-1:0] TAG_FCR  = 5'b11110;
  localparam logic [TAG_W-1:0] TAG_VRAM = 5'b11111;

  typedef struct packed {
    logic                active;
    logic [1:0]          frame;
    logic                vecLock;
    logic                userRam;
    logic [NUM_REGS-1:0] regWr;
  } pagerCtrl_t;
endpackage

// File: rtl/mpu_ctrl.sv
module mpu_ctrl
  import mpu_pkg::*;
(
  input  logic              memReq,
  input  logic              wrEn,
  input  logic [CPU_AW-1:0] cpuAddr,
  output pagerCtrl_t        ctrl
);
  localparam int REG_AW = $clog2(NUM_REGS);

  logic regWindow;
  assign regWindow = &cpuAddr[CPU_AW-1:REG_AW];

  always_comb begin
    ctrl.active  = memReq;
    ctrl.frame   = cpuAddr[CPU_AW-1:FRAME_AW];
    ctrl.vecLock = (cpuAddr[CPU_AW-1:VEC_AW] == '0);
    ctrl.userRam = &cpuAddr[CPU_AW-1:FRAME_AW];
    for (int i = 0; i < NUM_REGS; i++) begin
      ctrl.regWr[i] = memReq && wrEn && regWindow &&
                      (cpuAddr[REG_AW-1:0] == REG_AW'(i));
    end
  end
endmodule

// File: rtl/mpu_datapath.sv
module mpu_datapath
  import mpu_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  pagerCtrl_t          ctrl,
  input  logic [FRAME_AW-1:0] offset,
  input  logic [BANK_W-1:0]   wrData,
  output logic [PA_W-1:0]     physAddr,
  output logic                romSel,
  output logic                bramSel,
  output logic                uramSel,
  output logic                vramSel
);
  localparam int URAM_PAD = PA_W - TAG_W - URAM_AW;

  logic [NUM_FRAMES-1:0][BANK_W-1:0] bankReg;
  logic ramPage, ramEn, vidEn;
  logic [BANK_W-1:0] curBank;
  logic [TAG_W-1:0]  topTag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int f = 0; f < NUM_FRAMES; f++) bankReg[f] <= BANK_W'(f);
      ramPage <= 1'b0;
      ramEn   <= 1'b0;
      vidEn   <= 1'b0;
    end else begin
      for (int f = 0; f < NUM_FRAMES; f++)
        if (ctrl.regWr[f+1]) bankReg[f] <= wrData;
      if (ctrl.regWr[0]) begin
        ramPage <= wrData[2];
        ramEn   <= wrData[3];
        vidEn   <= wrData[4];
      end
    end
  end

  always_comb begin
    case (ctrl.frame)
      2'd0:    curBank = ctrl.vecLock ? '0 : bankReg[0];
      2'd1:    curBank = bankReg[1];
      default: curBank = bankReg[2];
    endcase
  end

  always_comb begin
    if (ctrl.userRam)
      physAddr = {TAG_URAM, {URAM_PAD{1'b0}}, offset[URAM_AW-1:0]};
    else if (ctrl.frame == 2'd2 && ramEn)
      physAddr = {TAG_BRAM, ramPage, offset};
    else if (ctrl.frame == 2'd2 && vidEn)
      physAddr = {TAG_VRAM, 1'b0, offset};
    else
      physAddr = {1'b0, curBank, offset};
  end

  assign topTag  = physAddr[PA_W-1 -: TAG_W];
  assign romSel  = ctrl.active && !topTag[TAG_W-1];
  assign uramSel = ctrl.active && (topTag == TAG_URAM);
  assign vramSel = ctrl.active && (topTag == TAG_VRAM);
  assign bramSel = ctrl.active && topTag[TAG_W-1] &&
                   (topTag != TAG_URAM) && (topTag != TAG_VRAM) && (topTag != TAG_FCR);
endmodule

// File: rtl/memory_pager.sv
module memory_pager
  import mpu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              memReq,
  input  logic              wrEn,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic [7:0]        wrData,
  output logic [PA_W-1:0]   physAddr,
  output logic              romSel,
  output logic              bramSel,
  output logic              uramSel,
  output logic              vramSel
);
  pagerCtrl_t ctrl;
  logic unusedData;
  assign unusedData = ^wrData[7:BANK_W];

  mpu_ctrl ctrl_i (
    .memReq (memReq),
    .wrEn   (wrEn),
    .cpuAddr(cpuAddr),
    .ctrl   (ctrl)
  );

  mpu_datapath dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .offset  (cpuAddr[FRAME_AW-1:0]),
    .wrData  (wrData[BANK_W-1:0]),
    .physAddr(physAddr),
    .romSel  (romSel),
    .bramSel (bramSel),
    .uramSel (uramSel),
    .vramSel (vramSel)
  );
endmodule

// File: rtl/memory_pager_chk.sv
module memory_pager_chk
  import mpu_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              wrEn,
  input logic [CPU_AW-1:0] cpuAddr,
  input logic [7:0]        wrData,
  input logic [PA_W-1:0]   physAddr,
  input logic              romSel,
  input logic              bramSel,
  input logic              uramSel,
  input logic              vramSel
);
  logic [3:0] sels;
  assign sels = {romSel, bramSel, uramSel, vramSel};

  p_one_select_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> $countones(sels) == 1);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !memReq |-> sels == 4'b0000);

  p_vector_pinned_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && cpuAddr[CPU_AW-1:VEC_AW] == '0) |->
      (romSel && physAddr[PA_W-1:FRAME_AW] == '0));

  p_user_mirror_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && &cpuAddr[CPU_AW-1:FRAME_AW]) |->
      (uramSel && physAddr[PA_W-1 -: TAG_W] == TAG_URAM &&
       physAddr[URAM_AW-1:0] == cpuAddr[URAM_AW-1:0]));

  p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !(&cpuAddr[CPU_AW-1:FRAME_AW])) |->
      physAddr[FRAME_AW-1:0] == cpuAddr[FRAME_AW-1:0]);

  p_bank_store_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(memReq && wrEn && cpuAddr == 16'hFFFE) && memReq &&
     cpuAddr[CPU_AW-1:FRAME_AW] == 2'd1) |->
      physAddr[PA_W-2:FRAME_AW] == $past(wrData[BANK_W-1:0]));
endmodule

bind memory_pager memory_pager_chk chk_i (.*);

// File: tb/memory_pager_tb_top.sv
module memory_pager_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memReq = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  wrData = '0;
  logic [19:0] physAddr;
  logic        romSel, bramSel, uramSel, vramSel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [19:0] ePhys;
    logic [3:0]  eSel;
    string       tag;
  } expItem_t;
  expItem_t sbQ[$];

  localparam logic [3:0] S_ROM = 4'b1000, S_BRAM = 4'b0100,
                         S_URAM = 4'b0010, S_VRAM = 4'b0001, S_NONE = 4'b0000;

  always #4 clk = ~clk;

  memory_pager dut_i (
    .clk(clk), .rstN(rstN), .memReq(memReq), .wrEn(wrEn),
    .cpuAddr(cpuAddr), .wrData(wrData), .physAddr(physAddr),
    .romSel(romSel), .bramSel(bramSel), .uramSel(uramSel), .vramSel(vramSel)
  );

  task automatic drive(input logic req, input logic we, input logic [15:0] a,
                       input logic [7:0] d, input logic [19:0] ePhys,
                       input logic [3:0] eSel, input string tag);
    expItem_t it;
    @(negedge clk);
    memReq = req; wrEn = we; cpuAddr = a; wrData = d;
    it.ePhys = ePhys; it.eSel = eSel; it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic rd(input logic [15:0] a, input logic [19:0] e,
                    input logic [3:0] s, input string tag);
    drive(1'b1, 1'b0, a, 8'h00, e, s, tag);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    drive(1'b1, 1'b1, a, d, {5'b11101, 2'b00, a[12:0]}, S_URAM, tag);
  endtask

  initial begin : monitor
    expItem_t it;
    logic [3:0] got;
    forever begin
      @(negedge clk);
      #2;
      if (sbQ.size() > 0) begin
        it  = sbQ.pop_front();
        got = {romSel, bramSel, uramSel, vramSel};
        checks++;
        if (got !== it.eSel || (it.eSel != S_NONE && physAddr !== it.ePhys)) begin
          fails++;
          $display("FAIL %s: sel=%b phys=%h expected sel=%b phys=%h",
                   it.tag, got, physAddr, it.eSel, it.ePhys);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset mapping
    rd(16'h4123, 20'h04123, S_ROM, "R1 frame1 reset bank");
    rd(16'h8123, 20'h08123, S_ROM, "R1 frame2 reset bank");
    rd(16'h1234, 20'h01234, S_ROM, "R1 frame0 reset bank");
    // R5/R6 store to frame-0 register also hits user RAM
    wr(16'hFFFD, 8'h07, "R6 register store selects user RAM");
    rd(16'h2345, 20'h1E345, S_ROM, "R2 frame0 bank 7");
    rd(16'h0123, 20'h00123, S_ROM, "R3 vector area bank 0");
    rd(16'h03FF, 20'h003FF, S_ROM, "R3 vector area top");
    rd(16'h0400, 20'h1C400, S_ROM, "R2 first paged byte");
    // R4/R5 frame 1 and 2 banks, bank field five bits
    wr(16'hFFFE, 8'hFF, "R5 store frame1");
    rd(16'h4000, 20'h7C000, S_ROM, "R5 frame1 bank uses low five bits");
    wr(16'hFFFF, 8'h10, "R5 store frame2");
    rd(16'hBFFF, 20'h43FFF, S_ROM, "R4 frame2 bank 16");
    // R9 idle store ignored
    drive(1'b0, 1'b1, 16'hFFFD, 8'h1F, 20'h0, S_NONE, "R9 idle no select");
    rd(16'h2000, 20'h1E000, S_ROM, "R9 frame0 unchanged after idle store");
    // R5 read of register address changes nothing
    rd(16'hFFFE, 20'hE9FFE, S_URAM, "R5 register read hits user RAM");
    rd(16'h4001, 20'h7C001, S_ROM, "R5 frame1 unchanged after read");
    // R6 mirror
    rd(16'hC010, 20'hE8010, S_URAM, "R6 user RAM low half");
    rd(16'hE010, 20'hE8010, S_URAM, "R6 user RAM mirror");
    // R7 battery RAM substitution
    wr(16'hFFFC, 8'h08, "R7 enable battery RAM");
    rd(16'h8005, 20'h80005, S_BRAM, "R7 battery page 0");
    wr(16'hFFFC, 8'h0C, "R7 battery page 1");
    rd(16'h8005, 20'h84005, S_BRAM, "R7 battery page 1");
    rd(16'h4001, 20'h7C001, S_ROM, "R7 frame1 unaffected");
    rd(16'h3001, 20'h1F001, S_ROM, "R7 frame0 unaffected");
    // R8 video memory and priority
    wr(16'hFFFC, 8'h10, "R8 enable video window");
    rd(16'h8005, 20'hF8005, S_VRAM, "R8 frame2 video memory");
    wr(16'hFFFC, 8'h18, "R8 both bits set");
    rd(16'h8005, 20'h80005, S_BRAM, "R8 battery RAM wins");
    wr(16'hFFFC, 8'h00, "R7 clear config");
    rd(16'h8005, 20'h40005, S_ROM, "R7 frame2 back to ROM bank 16");
    // R1 second reset restores mapping
    @(negedge clk);
    memReq = 1'b0; wrEn = 1'b0; rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    rd(16'h4123, 20'h04123, S_ROM, "R1 frame1 after second reset");
    rd(16'h2345, 20'h02345, S_ROM, "R1 frame0 after second reset");
    drive(1'b0, 1'b0, 16'h0000, 8'h00, 20'h0, S_NONE, "R9 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule